// File: doc/BRIEF.md
# Byte-Code Register Write Sequencer

This block runs a short byte-code program held in a local word memory and turns it into a stream of register writes on a simple write-only port. The program keeps a 32-bit address register and a 32-bit data register up to date, with either full-width loads or loads of the low 16 bits only. Completing an address load emits one write that carries the new address and the current data value. The program can also set or clear any of 32 single-bit flags, stall until a flag reaches a given value, and pause for a power-of-four scaled number of microsecond ticks.

A host fills the program memory one 32-bit word at a time and pulses a start input. It then polls a status word until the busy bit drops. Opcodes are read from each word starting with the least significant byte. Hardware can raise any flag with a one-cycle pulse on a set input, which lets a program wait on an outside event.

Top module: `regseq_engine`

## Requirements
- R1: Opcode 0xE0 takes the next four bytes, least significant first, as the full address. When the fourth byte is taken, one write pulse (`regWe` high for one cycle) appears in the next cycle, with `regAddr` set to the new address and `regData` set to the current data register.
- R2: Opcode 0x40 takes the next two bytes, least significant first, into address bits 15:0 and keeps bits 31:16. A write is then issued exactly as in R1.
- R3: Opcode 0xE2 loads the full data register from the next four bytes, and opcode 0x42 loads only data bits 15:0 from the next two bytes. Neither issues a write.
- R4: Opcodes 0xA0–0xBF clear flag (op & 0x1F), and opcodes 0xC0–0xDF set flag (op & 0x1F). Opcodes 0x80–0x9F leave every flag unchanged. Flags change at no other time except through `flagHwSet`.
- R5: Opcode 0x5F takes a flag-number byte (bits 4:0 are used) and then a value byte (bit 0 is used). Execution stalls until that flag equals that value. A high bit of `flagHwSet` sets the matching flag.
- R6: An opcode 0x00–0x3F with m = bits 1:0 and s = bits 5:2 holds execution for m × 4^s rising `usTick` cycles. m = 0 gives no pause.
- R7: A `startReq` pulse while idle starts execution at byte 0. Status bit 8 is 1 while running. Opcode 0x7F ends the program and clears bit 8. A start pulse while busy is ignored.
- R8: Any opcode not listed in R1–R7 ends the program and sets status bit 9. The next start clears bit 9.
- R9: Program-memory writes are ignored while status bit 8 is 1.
- R10: Running past the last byte of the memory ends the program as 0x7F does, with status bit 9 left clear.
- R11: After reset, the status word and the flags are 0 and `regWe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progWe | input | 1 | Program word write enable |
| progIdx | input | $clog2(DEPTH) | Program word index |
| progData | input | 32 | Program word; byte 0 is executed first |
| startReq | input | 1 | Start pulse |
| usTick | input | 1 | One-cycle pulse per microsecond |
| flagHwSet | input | 32 | Per-flag set pulses from hardware |
| status | output | 16 | Bit 8 busy, bit 9 error, other bits 0 |
| flagState | output | 32 | Current flag bank |
| regWe | output | 1 | Register write strobe |
| regAddr | output | 32 | Register write address |
| regData | output | 32 | Register write data |

## Verification
The engine consumes one byte per clock. A write therefore appears one cycle after the last address byte is taken, busy rises at the edge after the start pulse, and a pause releases on the edge that takes its final tick. The bench drives inputs and samples outputs on falling edges. A monitor catches each one-cycle write pulse, and results are compared only after busy has dropped. The stall and pause tests instead check at fixed points inside the window, before the releasing event, that nothing has been written and busy is still high. For the pause test, the ticks are driven by hand only after the engine has entered its wait, so the count of ticks is exact.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int NFLAG = 32;

  localparam logic [7:0] OP_ADDR_FULL = 8'hE0;
  localparam logic [7:0] OP_ADDR_LOW  = 8'h40;
  localparam logic [7:0] OP_DATA_FULL = 8'hE2;
  localparam logic [7:0] OP_DATA_LOW  = 8'h42;
  localparam logic [7:0] OP_WAIT_FLAG = 8'h5F;
  localparam logic [7:0] OP_END       = 8'h7F;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_OPND, S_WAIT, S_DELAY
  } seqState_t;

  typedef enum logic [2:0] {
    K_ADDR_FULL, K_ADDR_LOW, K_DATA_FULL, K_DATA_LOW, K_WAIT
  } opKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic        ldAddrFull;
    logic        ldAddrLow;
    logic        ldDataFull;
    logic        ldDataLow;
    logic        flagWr;
    logic        flagVal;
    logic [4:0]  flagIdx;
    logic [31:0] value;
  } seqStrobe_t;
endpackage

// File: rtl/regseq_progmem.sv
module regseq_progmem #(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [31:0]   wrData,
  input  logic [IW-1:0] rdIdx,
  output logic [31:0]   rdWord
);
  logic [31:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) words[wrIdx] <= wrData;
  end

  assign rdWord = words[rdIdx];
endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
  import regseq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             usTick,
  input  logic [31:0]      rdWord,
  input  logic [NFLAG-1:0] flagState,
  output logic [IW-1:0]    rdIdx,
  output seqStrobe_t       stb,
  output logic             busy,
  output logic             errSticky
);
  localparam int PCW = IW + 3;
  localparam logic [PCW-1:0] PC_END = PCW'(DEPTH * 4);

  seqState_t      state;
  opKind_t        kind;
  logic [PCW-1:0] pc;
  logic [2:0]     left;
  logic [1:0]     idx;
  logic [31:0]    opnd;
  logic [31:0]    dly;
  logic [4:0]     waitIdx;
  logic           waitVal;

  logic        atEnd;
  logic [7:0]  curByte;
  logic [31:0] assembled;
  logic        lastOpnd;

  assign atEnd     = (pc == PC_END);
  assign rdIdx     = pc[IW+1:2];
  assign curByte   = atEnd ? OP_END : rdWord[{pc[1:0], 3'b000} +: 8];
  assign assembled = opnd | (32'(curByte) << {idx, 3'b000});
  assign lastOpnd  = (state == S_OPND) && !atEnd && (left == 3'd1);
  assign busy      = (state != S_IDLE);

  always_comb begin
    stb            = '0;
    stb.value      = assembled;
    stb.flagIdx    = curByte[4:0];
    stb.flagVal    = curByte[6];
    stb.flagWr     = (state == S_OPC) && !atEnd &&
                     (curByte[7:5] == 3'b101 || curByte[7:5] == 3'b110);
    stb.ldAddrFull = lastOpnd && (kind == K_ADDR_FULL);
    stb.ldAddrLow  = lastOpnd && (kind == K_ADDR_LOW);
    stb.ldDataFull = lastOpnd && (kind == K_DATA_FULL);
    stb.ldDataLow  = lastOpnd && (kind == K_DATA_LOW);
  end

  task automatic beginOperands(input opKind_t k, input logic [2:0] n);
    kind  <= k;
    left  <= n;
    idx   <= 2'd0;
    opnd  <= '0;
    state <= S_OPND;
  endtask

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kind    <= K_ADDR_FULL;
      pc      <= '0;
      left    <= '0;
      idx     <= '0;
      opnd    <= '0;
      dly     <= '0;
      waitIdx <= '0;
      waitVal <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (startReq) begin
          state     <= S_OPC;
          pc        <= '0;
          errSticky <= 1'b0;
        end
        S_OPC: begin
          pc <= pc + PCW'(1);
          if (atEnd) state <= S_IDLE;
          else begin
            casez (curByte)
              8'b00??_????: if (curByte[1:0] != 2'd0) begin
                dly   <= {30'd0, curByte[1:0]} << {curByte[5:2], 1'b0};
                state <= S_DELAY;
              end
              OP_ADDR_FULL: beginOperands(K_ADDR_FULL, 3'd4);
              OP_ADDR_LOW:  beginOperands(K_ADDR_LOW,  3'd2);
              OP_DATA_FULL: beginOperands(K_DATA_FULL, 3'd4);
              OP_DATA_LOW:  beginOperands(K_DATA_LOW,  3'd2);
              OP_WAIT_FLAG: beginOperands(K_WAIT,      3'd2);
              8'b100?_????, 8'b101?_????, 8'b110?_????: ;
              OP_END:  state <= S_IDLE;
              default: begin
                state     <= S_IDLE;
                errSticky <= 1'b1;
              end
            endcase
          end
        end
        S_OPND: begin
          if (atEnd) state <= S_IDLE;
          else begin
            pc   <= pc + PCW'(1);
            opnd <= assembled;
            idx  <= idx + 2'd1;
            left <= left - 3'd1;
            if (left == 3'd1) begin
              if (kind == K_WAIT) begin
                waitIdx <= opnd[4:0];
                waitVal <= curByte[0];
                state   <= S_WAIT;
              end else state <= S_OPC;
            end
          end
        end
        S_WAIT: if (flagState[waitIdx] == waitVal) state <= S_OPC;
        S_DELAY: if (usTick) begin
          dly <= dly - 32'd1;
          if (dly == 32'd1) state <= S_OPC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regseq_dp.sv
module regseq_dp
  import regseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  input  logic [NFLAG-1:0] flagHwSet,
  output logic [NFLAG-1:0] flagState,
  output logic             regWe,
  output logic [31:0]      regAddr,
  output logic [31:0]      regData
);
  logic [NFLAG-1:0] flagsNext;

  always_comb begin
    flagsNext = flagState | flagHwSet;
    if (stb.flagWr) flagsNext[stb.flagIdx] = stb.flagVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagState <= '0;
      regWe     <= 1'b0;
      regAddr   <= '0;
      regData   <= '0;
    end else begin
      flagState <= flagsNext;
      regWe     <= stb.ldAddrFull | stb.ldAddrLow;
      if (stb.ldAddrFull)     regAddr       <= stb.value;
      else if (stb.ldAddrLow) regAddr[15:0] <= stb.value[15:0];
      if (stb.ldDataFull)     regData       <= stb.value;
      else if (stb.ldDataLow) regData[15:0] <= stb.value[15:0];
    end
  end
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
  import regseq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             progWe,
  input  logic [IW-1:0]    progIdx,
  input  logic [31:0]      progData,
  input  logic             startReq,
  input  logic             usTick,
  input  logic [NFLAG-1:0] flagHwSet,
  output logic [15:0]      status,
  output logic [NFLAG-1:0] flagState,
  output logic             regWe,
  output logic [31:0]      regAddr,
  output logic [31:0]      regData
);
  seqStrobe_t    stb;
  logic          busy;
  logic          errSticky;
  logic [IW-1:0] rdIdx;
  logic [31:0]   rdWord;

  assign status = {6'd0, errSticky, busy, 8'd0};

  regseq_progmem #(.DEPTH(DEPTH), .IW(IW)) u_mem (
    .clk(clk), .wrEn(progWe && !busy), .wrIdx(progIdx), .wrData(progData),
    .rdIdx(rdIdx), .rdWord(rdWord)
  );

  regseq_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .usTick(usTick),
    .rdWord(rdWord), .flagState(flagState), .rdIdx(rdIdx), .stb(stb),
    .busy(busy), .errSticky(errSticky)
  );

  regseq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .flagHwSet(flagHwSet),
    .flagState(flagState), .regWe(regWe), .regAddr(regAddr), .regData(regData)
  );
endmodule

// File: rtl/regseq_checker.sv
module regseq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busyBit,
  input logic        errBit,
  input logic        regWe,
  input logic [31:0] regAddr,
  input logic [31:0] flagState,
  input logic [31:0] flagHwSet
);
  // R1: a write strobe lasts exactly one cycle
  p_we_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R2: the address only moves together with a write
  p_addr_with_we_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regAddr) |-> regWe);

  // R7: no write is seen while idle
  p_idle_no_we_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busyBit |-> !regWe);

  // R8: error is only reported once stopped
  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    errBit |-> !busyBit);

  // R4: flags hold while idle and no hardware set arrives
  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busyBit && $past(!busyBit) && ($past(flagHwSet) == 32'd0)) |-> $stable(flagState));
endmodule

bind regseq_engine regseq_checker u_chk (
  .clk(clk), .rstN(rstN), .busyBit(status[8]), .errBit(status[9]),
  .regWe(regWe), .regAddr(regAddr), .flagState(flagState), .flagHwSet(flagHwSet)
);

// File: tb/regseq_engine_bench.sv
`timescale 1ns/1ps
module regseq_engine_bench;
  localparam int DEPTH = 64;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rstN = 0, progWe = 0, startReq = 0, usTick = 0;
  logic [IW-1:0] progIdx = '0;
  logic [31:0] progData = '0, flagHwSet = '0;
  logic [15:0] status;
  logic [31:0] flagState, regAddr, regData;
  logic regWe;

  int checks = 0, fails = 0, wrCount = 0;
  logic [31:0] lastAddr = '0, lastData = '0;

  always #2.5 clk = ~clk;

  regseq_engine #(.DEPTH(DEPTH)) u_regseq_engine (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progIdx(progIdx), .progData(progData),
    .startReq(startReq), .usTick(usTick), .flagHwSet(flagHwSet), .status(status),
    .flagState(flagState), .regWe(regWe), .regAddr(regAddr), .regData(regData)
  );

  always @(negedge clk) if (regWe) begin
    wrCount++;
    lastAddr = regAddr;
    lastData = regData;
  end

  typedef struct packed {
    logic [4:0][31:0] words;
    logic [7:0]  nWr;
    logic [31:0] expAddr;
    logic [31:0] expData;
    logic        expErr;
  } vec_t;

  // R1 R2 R3 R8 program vectors (word 0 in the lowest slot)
  localparam vec_t VECS [4] = '{
    '{ {32'h7F7F7F7F, 32'h7F7F7F7F, 32'h7F7F0000, 32'h1000E011, 32'h223344E2},
       8'd1, 32'h00001000, 32'h11223344, 1'b0 },
    '{ {32'h7F7F7F7F, 32'h200840AA, 32'hBB420000, 32'h1000E011, 32'h223344E2},
       8'd2, 32'h00002008, 32'h1122AABB, 1'b0 },
    '{ {32'h7F7F7F7F, 32'h7F7F7F00, 32'h10400001, 32'h0004E012, 32'h345678E2},
       8'd2, 32'h00010010, 32'h12345678, 1'b0 },
    '{ {32'h7F7F7F7F, 32'h7F7F7F7F, 32'h7FFF0000, 32'h0000E000, 32'h000001E2},
       8'd1, 32'h00000000, 32'h00000001, 1'b1 }
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadWord(input int idx, input logic [31:0] w);
    @(negedge clk);
    progWe = 1; progIdx = IW'(idx); progData = w;
    @(negedge clk);
    progWe = 0;
  endtask

  task automatic startRun();
    @(negedge clk) startReq = 1;
    @(negedge clk) startReq = 0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (status[8] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, {req, " timeout"}, 32'(status), 32'h0);
  endtask

  task automatic tickOnce();
    @(negedge clk) usTick = 1;
    @(negedge clk) usTick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(status == 16'h0, "R11 status", 32'(status), 32'h0);
    check(flagState == 32'h0, "R11 flags", flagState, 32'h0);
    check(regWe == 1'b0, "R11 regWe", 32'(regWe), 32'h0);

    foreach (VECS[v]) begin
      for (int k = 0; k < 5; k++) loadWord(k, VECS[v].words[k]);
      base = wrCount;
      startRun();
      waitIdle("R7");
      repeat (2) @(negedge clk);
      check(wrCount - base == int'(VECS[v].nWr), "R1 write count", 32'(wrCount - base), 32'(VECS[v].nWr));
      check(lastAddr == VECS[v].expAddr, "R2 address", lastAddr, VECS[v].expAddr);
      check(lastData == VECS[v].expData, "R3 data", lastData, VECS[v].expData);
      check(status[9] == VECS[v].expErr, "R8 error bit", 32'(status[9]), 32'(VECS[v].expErr));
    end

    // R4: C3 sets 3, C5 sets 5, A5 clears 5, 83 leaves 3
    loadWord(0, 32'h83A5C5C3);
    loadWord(1, 32'h7F7F7F7F);
    startRun();
    waitIdle("R4");
    check(flagState == 32'h00000008, "R4 flag ops", flagState, 32'h00000008);

    // R5/R9: wait on flag 2 == 1, then load data and write address 0x10
    loadWord(0, 32'hE201025F);
    loadWord(1, 32'h000000AA);
    loadWord(2, 32'h000010E0);
    loadWord(3, 32'h7F7F7F00);
    base = wrCount;
    startRun();
    repeat (20) @(negedge clk);
    check(status[8] == 1'b1, "R5 stalled busy", 32'(status[8]), 32'h1);
    check(wrCount == base, "R5 no write while stalled", 32'(wrCount), 32'(base));
    loadWord(1, 32'h000000BB);
    @(negedge clk) flagHwSet = 32'h4;
    @(negedge clk) flagHwSet = 32'h0;
    waitIdle("R5");
    repeat (2) @(negedge clk);
    check(lastAddr == 32'h10, "R5 write after wait", lastAddr, 32'h10);
    check(lastData == 32'hAA, "R9 write while busy ignored", lastData, 32'hAA);
    check(flagState[2] == 1'b1, "R5 hardware flag set", 32'(flagState[2]), 32'h1);

    // R6: 3C = no pause, 06 = 2*4 ticks, then write address 0x20
    loadWord(0, 32'h20E0063C);
    loadWord(1, 32'h7F000000);
    base = wrCount;
    startRun();
    repeat (6) @(negedge clk);
    for (int t = 0; t < 7; t++) tickOnce();
    repeat (3) @(negedge clk);
    check(wrCount == base, "R6 no write before last tick", 32'(wrCount), 32'(base));
    check(status[8] == 1'b1, "R6 busy during pause", 32'(status[8]), 32'h1);
    tickOnce();
    repeat (10) @(negedge clk);
    check(wrCount == base + 1, "R6 write after last tick", 32'(wrCount), 32'(base + 1));
    check(lastAddr == 32'h20, "R6 address", lastAddr, 32'h20);
    check(status[8] == 1'b0, "R6 finished", 32'(status[8]), 32'h0);

    // R10: zero pauses everywhere, last byte sets flag 7, then run off the end
    for (int k = 0; k < DEPTH - 1; k++) loadWord(k, 32'h0);
    loadWord(DEPTH - 1, 32'hC7000000);
    startRun();
    waitIdle("R10");
    check(status[8] == 1'b0, "R10 ended past last word", 32'(status[8]), 32'h0);
    check(status[9] == 1'b0, "R10 no error", 32'(status[9]), 32'h0);
    check(flagState[7] == 1'b1, "R10 last byte ran", 32'(flagState[7]), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule